// File: doc/BRIEF.md
# Vectored interrupt controller

This block collects up to 128 raw interrupt inputs, turns them into pending requests and raises one interrupt line toward a processor. Each input has its own trigger type, its own priority and its own vector. Software reaches these settings through a window: it first writes the number of a source into a selector register. Reads and writes of the mode and vector registers then act on that source. Enable, disable, clear and force-pending are one-bit command writes that also act on the selected source.

When the line is raised, the handler reads the vector register. That read acknowledges the winning source, records the number of the source being serviced and raises the current service level to its priority. Only a strictly higher-priority request can then interrupt the handler. The previous level is saved on a small hardware stack. The handler closes with an end-of-interrupt write, which restores the saved level. A vector read with nothing to deliver returns a programmable spurious value. It still saves a level, so the end-of-interrupt write that software issues afterwards stays balanced.

Top module: `vic_top`

## Requirements
- R1: The selector register (offset 0x00) keeps the low 7 bits of a write and reads them back. Mode (0x04) and vector (0x08) accesses apply to the selected source. When the selected number is not below the parameter NSRC, reads of 0x04, 0x08 and 0x30 return zero, and mode, vector and command writes change nothing.
- R2: The mode register holds priority in bits [2:0], where 7 is the highest, and trigger type in bits [6:5]. The trigger codes are 0 high level, 1 rising edge, 2 low level and 3 falling edge. All other mode bits read as zero.
- R3: A write to 0x40 with bit 0 set enables the selected source. A write to 0x44 with bit 0 set disables it. Bit 0 of 0x30 shows the enable of the selected source.
- R4: A write to 0x48 with bit 0 set clears the selected source's pending latch. A write to 0x4c with bit 0 set forces the latch to 1. If a clear or an acknowledge falls in the same cycle as a qualifying edge or a force, the latch ends up set.
- R5: An edge source latches pending on its edge. A level source is pending exactly while its input is at its active level. Raw pending is readable, before masking, at 0x20 + 4k: bit j holds source 32k + j.
- R6: irq_out rises one clock after an enabled, pending source qualifies. A source qualifies when the stack is empty, or when its priority is strictly above the current level. Otherwise irq_out is low.
- R7: A read of 0x10 while a source qualifies returns the vector of the qualifying source with the highest priority, and the lowest source number wins ties. The read also sets the status register (0x18) to that source number, clears its pending latch, and makes its priority the current level.
- R8: A read of 0x10 when no source qualifies returns the spurious value written at 0x3c, sets status to 0 and leaves the current level unchanged.
- R9: Every read of 0x10 pushes the current level onto an 8-entry stack, and the push is dropped when the stack is full. Each write to 0x38 pops one level and restores it. After eight such writes the stack is empty.
- R10: Bit 0 of 0x34 reads the state of irq_out.
- R11: Read data appears on bus_rdata on the clock after bus_rd. A cycle with both bus_wr and bus_rd is treated as a write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| src_in | input | NSRC | Raw interrupt source inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The two functions that can fall in one cycle are the ending of a source's pending state and the arrival of a new request for that same source. A clear command or a vector-read acknowledge can coincide with an input edge or a force command. The bench provokes this by moving a source input in the exact cycle that it issues the clear write or the vector read. It then reads the raw pending word, and the latch must still be set. A behavioural model, advanced on every clock, judges irq_out and every read, so any ordering slip between the ending and the new request shows up as a miscompare.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int MAX_SRC = 128;
  localparam int PRIO_W  = 3;

  localparam logic [7:0] A_SEL   = 8'h00;
  localparam logic [7:0] A_MODE  = 8'h04;
  localparam logic [7:0] A_VEC   = 8'h08;
  localparam logic [7:0] A_IVEC  = 8'h10;
  localparam logic [7:0] A_STAT  = 8'h18;
  localparam logic [7:0] A_PEND0 = 8'h20;
  localparam logic [7:0] A_PEND1 = 8'h24;
  localparam logic [7:0] A_PEND2 = 8'h28;
  localparam logic [7:0] A_PEND3 = 8'h2c;
  localparam logic [7:0] A_MASK  = 8'h30;
  localparam logic [7:0] A_CORE  = 8'h34;
  localparam logic [7:0] A_EOI   = 8'h38;
  localparam logic [7:0] A_SPUR  = 8'h3c;
  localparam logic [7:0] A_EN    = 8'h40;
  localparam logic [7:0] A_DIS   = 8'h44;
  localparam logic [7:0] A_CLR   = 8'h48;
  localparam logic [7:0] A_SET   = 8'h4c;

  // trigger code: bit 0 selects edge, bit 1 selects inverted polarity
  typedef enum logic [1:0] {
    TRG_HIGH = 2'd0,
    TRG_RISE = 2'd1,
    TRG_LOW  = 2'd2,
    TRG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank import vic_pkg::*; #(
  parameter int NSRC = 32,
  parameter int IDXW = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSRC-1:0]               src_in,
  input  logic [IDXW-1:0]               sel_idx,
  input  logic                          wr_mode,
  input  logic [PRIO_W-1:0]             prio_w,
  input  logic [1:0]                    trig_w,
  input  logic                          cmd_en,
  input  logic                          cmd_dis,
  input  logic                          cmd_clr,
  input  logic                          cmd_set,
  input  logic                          ack,
  input  logic [IDXW-1:0]               ack_idx,
  output logic [NSRC-1:0]               raw_pend,
  output logic [NSRC-1:0]               active,
  output logic [NSRC-1:0]               en_o,
  output logic [NSRC-1:0][PRIO_W-1:0]   prio_o,
  output logic [NSRC-1:0][1:0]          trig_o
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic              hit, prev_q, latch_q, en_q;
    logic              is_edge, inv, edge_hit, lvl_on;
    logic              do_set, do_clr;
    logic [PRIO_W-1:0] prio_q;
    trig_e             trig_q;

    assign hit      = (sel_idx == IDXW'(g));
    assign is_edge  = trig_q[0];
    assign inv      = trig_q[1];
    assign edge_hit = is_edge & (inv ? (~src_in[g] & prev_q) : (src_in[g] & ~prev_q));
    assign lvl_on   = ~is_edge & (src_in[g] ^ inv);
    assign do_set   = (hit & cmd_set) | edge_hit;
    assign do_clr   = (hit & cmd_clr) | (ack & (ack_idx == IDXW'(g)));

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
        en_q    <= 1'b0;
        prio_q  <= '0;
        trig_q  <= TRG_HIGH;
      end else begin
        prev_q <= src_in[g];
        if (do_set)      latch_q <= 1'b1;
        else if (do_clr) latch_q <= 1'b0;
        if (hit && cmd_en)       en_q <= 1'b1;
        else if (hit && cmd_dis) en_q <= 1'b0;
        if (hit && wr_mode) begin
          prio_q <= prio_w;
          trig_q <= trig_e'(trig_w);
        end
      end
    end

    assign raw_pend[g] = latch_q | lvl_on;
    assign active[g]   = raw_pend[g] & en_q;
    assign en_o[g]     = en_q;
    assign prio_o[g]   = prio_q;
    assign trig_o[g]   = trig_q;

    // R4: a force command leaves the source pending on the next cycle
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (hit && cmd_set) |=> raw_pend[g]);
    // R4: an acknowledge with no new request leaves an edge source idle
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (ack && ack_idx == IDXW'(g) && is_edge && !edge_hit && !(hit && cmd_set) && !(hit && wr_mode))
      |=> !raw_pend[g]);
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
  parameter int NSRC = 32,
  parameter int IDXW = 5
) (
  input  logic [NSRC-1:0]             active,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        best_ok,
  output logic [IDXW-1:0]             best_idx,
  output logic [PRIO_W-1:0]           best_prio
);

  // strict compare: a later source must beat, not equal, to take over
  always_comb begin
    best_ok   = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!best_ok || prio[i] > best_prio)) begin
        best_ok   = 1'b1;
        best_idx  = IDXW'(i);
        best_prio = prio[i];
      end
    end
  end

  // R7: the winner is always one of the active sources
  always_comb begin
    if (best_ok) p_winner_active_r7: assert (active[best_idx]);
  end

endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack import vic_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [PRIO_W-1:0]            push_val,
  input  logic                         pop,
  output logic [PRIO_W-1:0]            cur_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o
);
  localparam int DW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [PRIO_W-1:0] cur_q;
  logic [DW-1:0]     depth_q;
  logic              full, empty;
  logic [AW-1:0]     wr_ptr, rd_ptr;

  assign full   = (depth_q == DW'(DEPTH));
  assign empty  = (depth_q == '0);
  assign wr_ptr = depth_q[AW-1:0];
  assign rd_ptr = AW'(depth_q - DW'(1));

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      depth_q <= '0;
    end else if (push && !full) begin
      cur_q   <= push_val;
      depth_q <= depth_q + DW'(1);
    end else if (pop && !empty) begin
      cur_q   <= mem[rd_ptr];
      depth_q <= depth_q - DW'(1);
    end
  end

  assign cur_o   = cur_q;
  assign depth_o = depth_q;

  p_depth_max_r9: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DW'(DEPTH));
  p_push_full_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (depth_q == DW'(DEPTH)));
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (depth_q == '0));
  p_push_grow_r9: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (depth_q == $past(depth_q) + DW'(1)));

endmodule

// File: rtl/vic_top.sv
module vic_top import vic_pkg::*; #(
  parameter int NSRC      = 32,
  parameter int STK_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DW   = $clog2(STK_DEPTH + 1);

  logic                        wr_en, rd_en, sel_ok;
  logic [6:0]                  sel_q, stat_q;
  logic [IDXW-1:0]             sel_idx;
  logic [31:0]                 spur_q;
  logic [NSRC-1:0]             raw_pend, active, en_o;
  logic [NSRC-1:0][PRIO_W-1:0] prio_o;
  logic [NSRC-1:0][1:0]        trig_o;
  logic                        best_ok;
  logic [IDXW-1:0]             best_idx;
  logic [PRIO_W-1:0]           best_prio, cur_prio;
  logic [DW-1:0]               depth;
  logic                        irq_want, irq_q, ack_rd, ack_hit, pop;
  logic [MAX_SRC-1:0]          pend_pad;
  logic [31:0]                 vec_mem [NSRC];
  logic [31:0]                 vec_q, other_q, rd_other;
  logic                        use_mem, use_mem_q;
  logic [IDXW-1:0]             vraddr;

  assign wr_en   = bus_wr;
  assign rd_en   = bus_rd & ~bus_wr;
  assign sel_ok  = (int'(sel_q) < NSRC);
  assign sel_idx = sel_q[IDXW-1:0];

  vic_src_bank #(.NSRC(NSRC), .IDXW(IDXW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .src_in   (src_in),
    .sel_idx  (sel_idx),
    .wr_mode  (wr_en && bus_addr == A_MODE && sel_ok),
    .prio_w   (bus_wdata[2:0]),
    .trig_w   (bus_wdata[6:5]),
    .cmd_en   (wr_en && bus_addr == A_EN  && bus_wdata[0] && sel_ok),
    .cmd_dis  (wr_en && bus_addr == A_DIS && bus_wdata[0] && sel_ok),
    .cmd_clr  (wr_en && bus_addr == A_CLR && bus_wdata[0] && sel_ok),
    .cmd_set  (wr_en && bus_addr == A_SET && bus_wdata[0] && sel_ok),
    .ack      (ack_hit),
    .ack_idx  (best_idx),
    .raw_pend (raw_pend),
    .active   (active),
    .en_o     (en_o),
    .prio_o   (prio_o),
    .trig_o   (trig_o)
  );

  vic_arbiter #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
    .active    (active),
    .prio      (prio_o),
    .best_ok   (best_ok),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  assign irq_want = best_ok && ((depth == '0) || (best_prio > cur_prio));
  assign ack_rd   = rd_en && (bus_addr == A_IVEC);
  assign ack_hit  = ack_rd && irq_want;
  assign pop      = wr_en && (bus_addr == A_EOI);

  vic_prio_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ack_rd),
    .push_val (ack_hit ? best_prio : cur_prio),
    .pop      (pop),
    .cur_o    (cur_prio),
    .depth_o  (depth)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      spur_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_want;
      if (wr_en && bus_addr == A_SEL)  sel_q  <= bus_wdata[6:0];
      if (wr_en && bus_addr == A_SPUR) spur_q <= bus_wdata;
      if (ack_rd) stat_q <= ack_hit ? 7'(best_idx) : 7'd0;
    end
  end

  // vector storage: one write port, one synchronous read port
  assign vraddr = (bus_addr == A_IVEC) ? best_idx : sel_idx;

  always_ff @(posedge clk) begin
    if (wr_en && bus_addr == A_VEC && sel_ok) vec_mem[sel_idx] <= bus_wdata;
    if (rd_en) vec_q <= vec_mem[vraddr];
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NSRC-1:0] = raw_pend;
  end

  assign use_mem = ((bus_addr == A_VEC) && sel_ok) || ((bus_addr == A_IVEC) && irq_want);

  always_comb begin
    case (bus_addr)
      A_SEL:   rd_other = {25'd0, sel_q};
      A_MODE:  rd_other = sel_ok ? {25'd0, trig_o[sel_idx], 2'b00, prio_o[sel_idx]} : 32'd0;
      A_IVEC:  rd_other = spur_q;
      A_STAT:  rd_other = {25'd0, stat_q};
      A_PEND0: rd_other = pend_pad[31:0];
      A_PEND1: rd_other = pend_pad[63:32];
      A_PEND2: rd_other = pend_pad[95:64];
      A_PEND3: rd_other = pend_pad[127:96];
      A_MASK:  rd_other = {31'd0, sel_ok & en_o[sel_idx]};
      A_CORE:  rd_other = {31'd0, irq_q};
      A_SPUR:  rd_other = spur_q;
      default: rd_other = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      other_q   <= '0;
      use_mem_q <= 1'b0;
    end else if (rd_en) begin
      other_q   <= rd_other;
      use_mem_q <= use_mem;
    end
  end

  assign bus_rdata = use_mem_q ? vec_q : other_q;
  assign irq_out   = irq_q;

  // R6: with no active source the line is low one clock later
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !best_ok |=> !irq_out);
  // R8: a vector read with nothing qualifying leaves status at zero
  p_status_spur_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !irq_want) |=> (stat_q == 7'd0));
  // R7: an acknowledged source becomes the current level
  p_level_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && depth < DW'(STK_DEPTH)) |=> (cur_prio == $past(best_prio)));

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] src_in = '0;
  logic          irq_out;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vic_top #(.NSRC(NS), .STK_DEPTH(8)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  bit [2:0]  m_pr [NS];
  bit [1:0]  m_tr [NS];
  bit [31:0] m_vec [NS];
  bit        m_en [NS], m_lat [NS], m_prev [NS];
  int        m_stk [8];
  int        m_sel, m_stat, m_cur, m_dep;
  bit [31:0] m_spur, m_rd;
  bit        m_rv, m_irq;

  always @(posedge clk) begin
    bit raw [NS];
    bit act [NS];
    bit ehit [NS];
    bit clr [NS];
    bit want, bo, rdop, selok;
    int bi, bp, seln;
    bit [31:0] w;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_pr[i] = 0; m_tr[i] = 0; m_en[i] = 0; m_lat[i] = 0; m_prev[i] = 0;
      end
      m_sel = 0; m_stat = 0; m_cur = 0; m_dep = 0; m_spur = 0; m_rv = 0; m_irq = 0;
    end else begin
      for (int i = 0; i < NS; i++) begin
        bit e, v;
        e = m_tr[i][0]; v = m_tr[i][1];
        raw[i]  = m_lat[i] | (!e && (src_in[i] ^ v));
        act[i]  = raw[i] & m_en[i];
        ehit[i] = e && (v ? (!src_in[i] && m_prev[i]) : (src_in[i] && !m_prev[i]));
        clr[i]  = 0;
      end
      bo = 0; bi = 0; bp = 0;
      for (int i = 0; i < NS; i++)
        if (act[i] && (!bo || m_pr[i] > bp)) begin bo = 1; bi = i; bp = m_pr[i]; end
      want  = bo && (m_dep == 0 || bp > m_cur);
      rdop  = bus_rd && !bus_wr;
      selok = m_sel < NS;
      seln  = m_sel;
      w     = bus_wdata;
      m_rv  = rdop;
      if (rdop) begin
        w = 0;
        for (int i = 0; i < NS; i++) w[i] = raw[i];
        case (bus_addr)
          8'h00: m_rd = m_sel;
          8'h04: m_rd = selok ? ((32'(m_tr[seln]) << 5) | 32'(m_pr[seln])) : 0;
          8'h08: m_rd = selok ? m_vec[seln] : 0;
          8'h10: m_rd = want ? m_vec[bi] : m_spur;
          8'h18: m_rd = m_stat;
          8'h20: m_rd = w;
          8'h30: m_rd = selok ? 32'(m_en[seln]) : 0;
          8'h34: m_rd = 32'(m_irq);
          8'h3c: m_rd = m_spur;
          default: m_rd = 0;
        endcase
        if (bus_addr == 8'h10) begin
          if (m_dep < 8) begin
            m_stk[m_dep] = m_cur;
            if (want) m_cur = bp;
            m_dep++;
          end
          m_stat = want ? bi : 0;
          if (want) clr[bi] = 1;
        end
      end
      w = bus_wdata;
      if (bus_wr) begin
        if (selok && w[0]) begin
          if (bus_addr == 8'h48) clr[seln] = 1;
          if (bus_addr == 8'h4c) ehit[seln] = 1;
        end
      end
      for (int i = 0; i < NS; i++) begin
        if (ehit[i]) m_lat[i] = 1;
        else if (clr[i]) m_lat[i] = 0;
        m_prev[i] = src_in[i];
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_sel = int'(w[6:0]);
          8'h04: if (selok) begin m_pr[seln] = w[2:0]; m_tr[seln] = w[6:5]; end
          8'h08: if (selok) m_vec[seln] = w;
          8'h3c: m_spur = w;
          8'h38: if (m_dep > 0) begin m_dep--; m_cur = m_stk[m_dep]; end
          8'h40: if (selok && w[0]) m_en[seln] = 1;
          8'h44: if (selok && w[0]) m_en[seln] = 0;
          default: ;
        endcase
      end
      m_irq = want;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (irq_out !== m_irq) begin
        fails++;
        $display("FAIL R6 model irq_out actual=%0b expected=%0b t=%0t", irq_out, m_irq, $time);
      end
      if (m_rv) begin
        vectors++;
        if (bus_rdata !== m_rd) begin
          fails++;
          $display("FAIL R11 model read addr=%h actual=%h expected=%h t=%0t",
                   bus_addr, bus_rdata, m_rd, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk); @(negedge clk);
    chk(tag, 32'(irq_out), 32'(exp));
  endtask

  task automatic pick(input int s); wr(8'h00, 32'(s)); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    rd_chk(8'h34, 0, "R10 reset core status");
    rd_chk(8'h18, 0, "R7 reset status");
    chk("R6 reset irq", 32'(irq_out), 0);

    for (int i = 0; i < NS; i++) begin pick(i); wr(8'h08, 32'h1000 + i); end
    wr(8'h3c, 32'hDEAD);

    // R1 / R2 window and field layout
    pick(5); wr(8'h04, 32'hFF);
    rd_chk(8'h04, 32'h67, "R2 mode fields");
    wr(8'h04, 32'h23);
    rd_chk(8'h04, 32'h23, "R2 mode rising prio3");
    rd_chk(8'h08, 32'h1005, "R1 vector of selected");
    wr(8'h00, 32'h85);
    rd_chk(8'h00, 32'h05, "R1 select low bits");
    pick(40); wr(8'h04, 32'h7); wr(8'h40, 1);
    rd_chk(8'h04, 0, "R1 unimplemented mode");
    rd_chk(8'h08, 0, "R1 unimplemented vector");
    rd_chk(8'h30, 0, "R1 unimplemented enable");

    // R3 enable / disable
    pick(5); wr(8'h40, 1);
    rd_chk(8'h30, 1, "R3 enabled");
    wr(8'h44, 1);
    rd_chk(8'h30, 0, "R3 disabled");
    wr(8'h40, 1);

    // R5 edge latch and level follow
    @(negedge clk); src_in[5] = 1; @(negedge clk); src_in[5] = 0;
    rd_chk(8'h20, 32'h20, "R5 edge latched");
    pick(9); wr(8'h04, 32'h02); wr(8'h40, 1);
    @(negedge clk); src_in[9] = 1;
    rd_chk(8'h20, 32'h220, "R5 level high");
    @(negedge clk); src_in[9] = 0;
    rd_chk(8'h20, 32'h20, "R5 level follows input");
    irq_chk(1, "R6 pending source raises irq");

    // R7 acknowledge
    rd_chk(8'h10, 32'h1005, "R7 vector of winner");
    rd_chk(8'h18, 5, "R7 status number");
    rd_chk(8'h20, 0, "R7 edge latch cleared");
    irq_chk(0, "R6 irq drops after ack");

    // nesting
    pick(12); wr(8'h04, 32'h65); wr(8'h40, 1);
    @(negedge clk); src_in[12] = 1; @(negedge clk); src_in[12] = 0;
    irq_chk(1, "R6 higher priority preempts");
    rd_chk(8'h10, 32'h100C, "R7 nested vector");
    pick(20); wr(8'h04, 32'h45); wr(8'h40, 1);
    irq_chk(0, "R6 equal priority waits");
    wr(8'h38, 0);
    irq_chk(1, "R9 pop restores lower level");
    rd_chk(8'h10, 32'h1014, "R7 low-level source vector");

    // R8 spurious
    pick(20); wr(8'h44, 1);
    rd_chk(8'h10, 32'hDEAD, "R8 spurious vector");
    rd_chk(8'h18, 0, "R8 spurious status");
    repeat (3) wr(8'h38, 0);

    // R7 tie: lowest number wins
    pick(3); wr(8'h04, 32'h04); wr(8'h40, 1); wr(8'h4c, 1);
    pick(7); wr(8'h04, 32'h04); wr(8'h40, 1); wr(8'h4c, 1);
    rd_chk(8'h10, 32'h1003, "R7 tie lowest number");
    irq_chk(0, "R6 tie peer blocked");
    wr(8'h38, 0);
    rd_chk(8'h10, 32'h1007, "R7 tie second");
    wr(8'h38, 0);

    // R4 clear / set and same-cycle collisions
    pick(3); wr(8'h4c, 1); wr(8'h48, 1);
    rd_chk(8'h20, 32'h0010_0000, "R4 clear removes pending");
    pick(5);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h48; bus_wdata = 1; src_in[5] = 1;
    @(negedge clk); bus_wr = 0;
    rd_chk(8'h20, 32'h0010_0020, "R4 edge beats clear");
    wr(8'h48, 1);
    rd_chk(8'h20, 32'h0010_0000, "R4 clear without edge");
    @(negedge clk); src_in[5] = 0;
    wr(8'h4c, 1);
    @(negedge clk); bus_rd = 1; bus_addr = 8'h10; src_in[5] = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
    chk("R4 ack collision vector", d, 32'h1005);
    rd_chk(8'h20, 32'h0010_0020, "R4 edge beats ack");
    wr(8'h38, 0); wr(8'h48, 1); wr(8'h44, 1);
    @(negedge clk); src_in[5] = 0;

    // R9 stack depth and unwind
    repeat (10) rd(8'h10, d);
    chk("R8 spurious at depth", d, 32'hDEAD);
    pick(30); wr(8'h40, 1);
    @(negedge clk); src_in[30] = 1;
    repeat (7) wr(8'h38, 0);
    irq_chk(0, "R9 seven pops still stacked");
    wr(8'h38, 0);
    irq_chk(1, "R9 eighth pop unwinds");
    rd_chk(8'h34, 1, "R10 core status high");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule